// File: doc/BRIEF.md
# Interrupt Transfer Request Router

This block sits between a set of peripheral interrupt lines and both the CPU interrupt logic and an external data-transfer engine. For each of sixteen routable interrupt sources, a software-programmed enable bit chooses the destination. When the bit is clear, the interrupt goes straight on to the CPU. When the bit is set, the interrupt is latched as a pending transfer request. The block then hands it to the transfer engine, one request at a time, in a fixed lowest-index-first order.

Each routable source has a 16-bit remaining-transfer counter. The counter drops by one each time the engine acknowledges a transfer for that source. The counter spans 1 to 65,536 transfers, and a written value of 0 stands for 65,536. When a transfer moves the counter from 1 to 0, the block raises a CPU interrupt that carries the index of the requesting source. It holds that interrupt until the CPU acknowledges it. A small group of fixed sources has no enable bit and is always passed to the CPU. Software reaches the enable registers and the counters over a single-cycle register bus.

Top module: `xfer_route`

## Requirements
- R1: After reset, every enable bit and every counter reads 0, `xfer_req` is 0 and `vec_valid` is 0.
- R2: Bus addresses 0 to 3 are four 8-bit enable registers, readable and writable. Addresses 16+i are the 16-bit counters of source i. Writes complete in one clock edge. `bus_rdata` shows the addressed register in the same cycle (bits above 7 read 0 for an enable register). Source i is enabled by bit 2*(i%4) of enable register i/4.
- R3: For a source whose enable bit is 0, `cpu_req[i]` equals `src_irq[i]` in the same cycle, and no transfer request is issued for it.
- R4: Odd-numbered bits of the enable registers store the written value but route nothing: a source with only odd bits set in its register still goes to `cpu_req`.
- R5: `fix_req` equals `fix_irq` in the same cycle, whatever the enable registers hold.
- R6: A `src_irq[i]` pulse on an enabled source keeps `cpu_req[i]` at 0. It produces `xfer_req`=1 with `xfer_src`=i from the second clock edge after the pulse.
- R7: A transfer acknowledge (`xfer_ack` while `xfer_req`) decrements the counter of `xfer_src` by one.
- R8: An acknowledge that takes a counter from 1 to 0 sets `vec_valid` with `vec_idx` equal to that source.
- R9: A counter holding 0 counts as 65,536: one transfer leaves it at 0xFFFF and raises no vector.
- R10: When several enabled sources are pending, transfers are granted in increasing source index.
- R11: At most one request is outstanding. `xfer_req` and `xfer_src` hold steady until acknowledged.
- R12: `vec_valid` and `vec_idx` hold until `vec_ack`. No new transfer request is issued while `vec_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_irq | input | 16 | Routable interrupt pulses, one per source |
| fix_irq | input | 4 | Interrupts that always go to the CPU |
| cpu_req | output | 16 | CPU interrupt requests for sources not enabled for transfer |
| fix_req | output | 4 | CPU interrupt requests for the fixed sources |
| xfer_req | output | 1 | Transfer request to the engine |
| xfer_src | output | 4 | Source index of the outstanding request |
| xfer_ack | input | 1 | Engine has completed the requested transfer |
| vec_valid | output | 1 | Counter-exhausted CPU interrupt pending |
| vec_idx | output | 4 | Source index carried by the exhausted interrupt |
| vec_ack | input | 1 | CPU accepts the exhausted interrupt |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |

## Verification
A wrong enable mapping or a lost enable bit shows up on `cpu_req` in the same cycle as the interrupt pulse, or as an unexpected request two edges later. A counter that decrements wrongly stays hidden until it is read over the bus, or until the vector comes early, late or never. So after every transfer sequence the counters are read back and the vector queue is compared. A corrupted pending set or priority choice shows up on the first grant as a wrong `xfer_src`, and the scoreboard catches it on the very request.

// File: rtl/xfer_route.sv
module xfer_route #(
  parameter int NSRC = 16,
  parameter int NFIX = 4,
  parameter int CW   = 16,
  localparam int NREG = NSRC / 4,
  localparam int SW   = $clog2(NSRC),
  localparam int RW   = $clog2(NREG),
  localparam int AW   = $clog2(2 * NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_irq,
  input  logic [NFIX-1:0] fix_irq,
  output logic [NSRC-1:0] cpu_req,
  output logic [NFIX-1:0] fix_req,
  output logic            xfer_req,
  output logic [SW-1:0]   xfer_src,
  input  logic            xfer_ack,
  output logic            vec_valid,
  output logic [SW-1:0]   vec_idx,
  input  logic            vec_ack,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [CW-1:0]   bus_wdata,
  output logic [CW-1:0]   bus_rdata
);

  logic [7:0]      en_r  [NREG];
  logic [CW-1:0]   cnt_r [NSRC];
  logic [NSRC-1:0] en_map, pend;
  logic            busy;
  logic [SW-1:0]   cur, pick;
  logic [CW-1:0]   cnt_cur;

  for (genvar g = 0; g < NSRC; g++) begin : g_map
    assign en_map[g] = en_r[g / 4][2 * (g % 4)];
  end

  assign cpu_req  = src_irq & ~en_map;
  assign fix_req  = fix_irq;
  assign xfer_req = busy;
  assign xfer_src = cur;

  wire           is_en  = bus_addr < AW'(NREG);
  wire           is_cnt = bus_addr >= AW'(NSRC);
  wire [SW-1:0]  cidx   = bus_addr[SW-1:0];
  wire           wr_en  = bus_wr && is_en;
  wire           wr_cnt = bus_wr && is_cnt;
  wire           hit    = wr_cnt && cidx == cur;
  wire           done   = busy && xfer_ack;
  wire           exhaust = done && cnt_cur == CW'(1);

  assign cnt_cur = hit ? bus_wdata : cnt_r[cur];

  always_comb begin
    pick = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) pick = SW'(i);
  end

  always_comb begin
    if (is_en)       bus_rdata = {{(CW-8){1'b0}}, en_r[bus_addr[RW-1:0]]};
    else if (is_cnt) bus_rdata = cnt_r[cidx];
    else             bus_rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) en_r[r] <= '0;
    end else if (wr_en) begin
      en_r[bus_addr[RW-1:0]] <= bus_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) cnt_r[i] <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if (wr_cnt && cidx == SW'(i)) cnt_r[i] <= bus_wdata;
        if (done && cur == SW'(i))    cnt_r[i] <= cnt_cur - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= '0;
      busy      <= 1'b0;
      cur       <= '0;
      vec_valid <= 1'b0;
      vec_idx   <= '0;
    end else begin
      pend <= (pend & ~({NSRC{done}} & (NSRC'(1) << cur))) | (src_irq & en_map);
      if (done)
        busy <= 1'b0;
      else if (!busy && !vec_valid && |pend) begin
        busy <= 1'b1;
        cur  <= pick;
      end
      if (exhaust) begin
        vec_valid <= 1'b1;
        vec_idx   <= cur;
      end else if (vec_ack) begin
        vec_valid <= 1'b0;
      end
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_src));

  // R12
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ack |=> vec_valid && $stable(vec_idx));

  // R12
  no_grant_in_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !$rose(xfer_req));

  // R7
  dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_ack && !hit |=> cnt_r[$past(xfer_src)] == $past(cnt_r[xfer_src]) - CW'(1));

  // R8
  exhaust_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_ack && !hit && cnt_r[xfer_src] == CW'(1) |=> vec_valid && vec_idx == $past(xfer_src));

endmodule

// File: tb/xfer_route_tb.sv
module xfer_route_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [15:0] src_irq = '0;
  logic [3:0]  fix_irq = '0;
  logic [15:0] cpu_req;
  logic [3:0]  fix_req;
  logic        xfer_req, xfer_ack = 0;
  logic [3:0]  xfer_src;
  logic        vec_valid, vec_ack = 0;
  logic [3:0]  vec_idx;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int checks = 0, errors = 0;
  int ack_delay = 0, vec_delay = 0;
  bit finished = 0;
  int exp_src[$];
  int exp_vec[$];

  xfer_route u_dut (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .fix_irq(fix_irq),
    .cpu_req(cpu_req), .fix_req(fix_req), .xfer_req(xfer_req),
    .xfer_src(xfer_src), .xfer_ack(xfer_ack), .vec_valid(vec_valid),
    .vec_idx(vec_idx), .vec_ack(vec_ack), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // engine model: pops expected grants and acknowledges
  initial begin
    int wcnt = 0;
    int held = -1;
    forever begin
      @(negedge clk);
      if (xfer_ack) begin
        xfer_ack = 0;
        held = -1;
      end else if (xfer_req) begin
        if (held >= 0) check("R11 src stable", int'(xfer_src), held);
        held = int'(xfer_src);
        if (wcnt < ack_delay) wcnt++;
        else begin
          wcnt = 0;
          if (exp_src.size() == 0) check("R3/R9 unexpected request", int'(xfer_src), -1);
          else check("R10 grant order", int'(xfer_src), exp_src.pop_front());
          xfer_ack = 1;
        end
      end
    end
  end

  // CPU model for exhausted vectors
  initial begin
    int wcnt = 0;
    forever begin
      @(negedge clk);
      if (vec_ack) vec_ack = 0;
      else if (vec_valid) begin
        if (xfer_req) check("R12 request during vector", 1, 0);
        if (wcnt < vec_delay) wcnt++;
        else begin
          wcnt = 0;
          if (exp_vec.size() == 0) check("R9 unexpected vector", int'(vec_idx), -1);
          else check("R8 vector index", int'(vec_idx), exp_vec.pop_front());
          vec_ack = 1;
        end
      end
    end
  end

  task automatic bus_write(int a, int d);
    @(negedge clk);
    bus_addr = 5'(a); bus_wdata = 16'(d); bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_check(string req, int a, int exp);
    @(negedge clk);
    bus_addr = 5'(a);
    #1 check(req, int'(bus_rdata), exp);
  endtask

  task automatic fire(logic [15:0] m, logic [15:0] exp_cpu, string req);
    @(negedge clk);
    src_irq = m;
    #1 check(req, int'(cpu_req), int'(exp_cpu));
    @(negedge clk);
    src_irq = '0;
  endtask

  task automatic drain();
    int t = 0;
    while ((exp_src.size() != 0 || exp_vec.size() != 0 || xfer_req || vec_valid) && t < 500) begin
      @(negedge clk); t++;
    end
    if (t >= 500) check("drain timeout", t, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    #1 check("R1 xfer_req", int'(xfer_req), 0);
    check("R1 vec_valid", int'(vec_valid), 0);
    for (int a = 0; a < 4; a++) bus_check("R1 enable reset", a, 0);
    bus_check("R1 count reset", 16, 0);
    bus_check("R1 count reset", 31, 0);
    // R2
    bus_write(0, 16'hA5); bus_check("R2 enable rw", 0, 16'hA5);
    bus_write(3, 16'hFF3C); bus_check("R2 enable rw 8 bit", 3, 16'h3C);
    bus_write(16 + 7, 16'h1234); bus_check("R2 count rw", 16 + 7, 16'h1234);
    bus_write(0, 0); bus_write(3, 0);
    // R3
    fire(16'h0080, 16'h0080, "R3 cpu route");
    drain();
    // R4
    bus_write(1, 16'hAA);
    bus_check("R4 odd bits stored", 1, 16'hAA);
    fire(16'h00F0, 16'h00F0, "R4 odd bits no routing");
    drain();
    bus_write(1, 0);
    // R5
    bus_write(0, 16'hFF);
    @(negedge clk); fix_irq = 4'b1010;
    #1 check("R5 fixed passthrough", int'(fix_req), 4'b1010);
    @(negedge clk); fix_irq = 0;
    // R6 R7 R8: source 3 is bit 6 of register 0
    bus_write(0, 16'h40);
    bus_write(16 + 3, 2);
    exp_src.push_back(3);
    fire(16'h0008, 16'h0000, "R6 enabled source hidden from cpu");
    @(negedge clk);
    check("R6 request issued", int'(xfer_req), 1);
    drain();
    bus_check("R7 count decremented", 16 + 3, 1);
    exp_src.push_back(3); exp_vec.push_back(3);
    fire(16'h0008, 16'h0000, "R6 second pulse");
    drain();
    bus_check("R8 count exhausted", 16 + 3, 0);
    // R9: source 8 is bit 0 of register 2
    bus_write(2, 16'h01);
    bus_write(16 + 8, 0);
    exp_src.push_back(8);
    fire(16'h0100, 16'h0000, "R9 pulse");
    drain();
    bus_check("R9 zero means 65536", 16 + 8, 16'hFFFF);
    // R10 R11: sources 2, 5, 9
    bus_write(0, 16'h50); bus_write(1, 16'h04); bus_write(2, 16'h05);
    bus_write(16 + 2, 100); bus_write(16 + 5, 100); bus_write(16 + 9, 100);
    ack_delay = 3;
    exp_src.push_back(2); exp_src.push_back(5); exp_src.push_back(9);
    fire(16'h0224, 16'h0000, "R10 multi pulse");
    drain();
    bus_check("R10 count src2", 16 + 2, 99);
    bus_check("R10 count src5", 16 + 5, 99);
    bus_check("R11 count src9", 16 + 9, 99);
    // R12
    ack_delay = 0; vec_delay = 4;
    bus_write(16 + 2, 1);
    exp_src.push_back(2); exp_vec.push_back(2); exp_src.push_back(5);
    fire(16'h0024, 16'h0000, "R12 pulses");
    drain();
    bus_check("R12 count src5", 16 + 5, 98);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule